// File: doc/BRIEF.md
# Serial Cyclic Syndrome Decoder

This block receives words of a (7,4) systematic cyclic code one bit per clock. The code is built on the generator polynomial x^3 + x^2 + 1. Each accepted bit enters a divide-by-generator shift register, and the same bit is appended to a word buffer. When the seventh bit arrives, the register holds the remainder of the received polynomial. That remainder is the syndrome.

A syndrome of zero means the word is accepted as it is. A non-zero syndrome is looked up in a single-error position map, which gives one error bit to flip. The block then presents the corrected word, its four data bits and an error flag for one cycle. The position map is computed at elaboration from the generator rather than written out as a table.

The block clears its division state by itself at each word boundary. Words can therefore follow each other with no idle cycle, and gaps in the input stream only pause the count. Correction is limited to one error per word. Patterns with two errors produce a syndrome that matches some single position, so they come out as a different valid codeword.

Top module: `cyc_syn_dec`

## Requirements
- R1: While reset is low and in the first cycle after it, out_valid is 0, and out_word, out_data and out_err are all 0.
- R2: The first bit accepted in a word is word bit 1. It lands in out_word[6], the most significant bit, so bit 7 lands in out_word[0]. out_data always equals out_word[6:3].
- R3: The syndrome is the remainder of the received polynomial divided by 1101 (bit 1 being the x^6 coefficient). If the syndrome is zero, out_err is 0 and out_word equals the received word.
- R4: Any codeword with exactly one bit flipped is restored to the original codeword, with out_err set to 1.
- R5: The map from syndrome (x^2 x^1 x^0) to the flipped position is: 110 to bit 1, 011 to bit 2, 111 to bit 3, 101 to bit 4, 100 to bit 5, 010 to bit 6, 001 to bit 7.
- R6: out_valid rises for exactly one cycle, in the cycle after the clock edge that accepts the seventh bit of a word.
- R7: The next word's first bit may be given in the cycle right after a word's seventh bit. A cycle with in_valid low is ignored and does not advance the bit count.
- R8: The received word 1010011 is corrected to 1010001, and 1011010 is corrected to 0011010.
- R9: A double error 0000011 or 1000001 on the all-zero codeword is miscorrected. The results are 0100011 and 1010001 respectively, both with out_err set to 1.
- R10: Every word presented with out_valid high is a codeword, meaning its remainder by 1101 is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | in_bit is accepted on this edge |
| in_bit | input | 1 | Received bit, word bit 1 first |
| out_valid | output | 1 | Single-cycle strobe marking a decoded word |
| out_word | output | 7 | Corrected codeword, bit 1 in the MSB |
| out_data | output | 4 | Data part of the corrected codeword |
| out_err | output | 1 | Syndrome was non-zero |

## Verification
All results are registered on the same edge that accepts the seventh bit, so they can be read one edge after that bit is sampled. The bench drives bits on falling edges. It reads a word's results on the falling edge that follows its seventh bit, which is the same edge on which the next word's first bit is driven. One cycle later the bench checks that out_valid has dropped again. When bits arrive with gaps, the check is moved to follow the seventh accepted bit rather than the seventh cycle.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
    localparam int unsigned CW_LEN  = 7;
    localparam int unsigned CW_CHK  = 3;
    localparam logic [3:0]  CW_POLY = 4'b1101;
endpackage

// File: rtl/cyc_div.sv
module cyc_div #(
    parameter int unsigned R = cyc_pkg::CW_CHK,
    parameter logic [R:0]  GEN = cyc_pkg::CW_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         restart,
    input  logic         bit_in,
    output logic [R-1:0] rem_nxt
);
    typedef struct packed {
        logic [R-1:0] rem;
    } div_t;

    div_t st_d, st_q;

    function automatic logic [R-1:0] div_step(input logic [R-1:0] r, input logic b);
        logic [R:0] t;
        t = {r, b};
        if (t[R]) t = t ^ GEN;
        return t[R-1:0];
    endfunction

    always_comb begin
        logic [R-1:0] base;
        st_d    = st_q;
        base    = restart ? '0 : st_q.rem;
        rem_nxt = div_step(base, bit_in);
        if (shift_en) st_d.rem = rem_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cyc_errmap.sv
module cyc_errmap #(
    parameter int unsigned N = cyc_pkg::CW_LEN,
    parameter int unsigned R = cyc_pkg::CW_CHK,
    parameter logic [R:0]  GEN = cyc_pkg::CW_POLY
) (
    input  logic [R-1:0] syn,
    output logic [N-1:0] err_vec
);
    function automatic logic [R-1:0] xpow_rem(input int p);
        logic [R:0]   t;
        logic [R-1:0] r;
        r = '0;
        r[0] = 1'b1;
        for (int i = 0; i < p; i++) begin
            t = {r, 1'b0};
            if (t[R]) t = t ^ GEN;
            r = t[R-1:0];
        end
        return r;
    endfunction

    for (genvar j = 0; j < N; j++) begin : g_pos
        localparam logic [R-1:0] POS_SYN = xpow_rem(j);
        assign err_vec[j] = (|syn) && (syn == POS_SYN);
    end
endmodule

// File: rtl/cyc_syn_dec.sv
module cyc_syn_dec #(
    parameter int unsigned N = cyc_pkg::CW_LEN,
    parameter int unsigned R = cyc_pkg::CW_CHK,
    parameter logic [R:0]  GEN = cyc_pkg::CW_POLY,
    localparam int unsigned K = N - R,
    localparam int unsigned CW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_bit,
    output logic         out_valid,
    output logic [N-1:0] out_word,
    output logic [K-1:0] out_data,
    output logic         out_err
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [N-1:0]  buf_w;
        logic          ovld;
        logic [N-1:0]  oword;
        logic          oerr;
    } dec_t;

    localparam logic [CW-1:0] LAST = CW'(N - 1);

    dec_t st_d, st_q;
    logic          first_bit;
    logic          last_bit;
    logic [R-1:0]  syn;
    logic [N-1:0]  err_vec;
    logic [N-1:0]  word_nxt;

    assign first_bit = (st_q.cnt == '0);
    assign last_bit  = (st_q.cnt == LAST);

    cyc_div #(.R(R), .GEN(GEN)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .restart  (first_bit),
        .bit_in   (in_bit),
        .rem_nxt  (syn)
    );

    cyc_errmap #(.N(N), .R(R), .GEN(GEN)) u_map (
        .syn     (syn),
        .err_vec (err_vec)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovld = 1'b0;
        word_nxt = first_bit ? {{(N-1){1'b0}}, in_bit}
                             : {st_q.buf_w[N-2:0], in_bit};
        if (in_valid) begin
            st_d.buf_w = word_nxt;
            st_d.cnt   = last_bit ? '0 : st_q.cnt + 1'b1;
            if (last_bit) begin
                st_d.ovld  = 1'b1;
                st_d.oword = word_nxt ^ err_vec;
                st_d.oerr  = |syn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ovld;
    assign out_word  = st_q.oword;
    assign out_data  = st_q.oword[N-1:R];
    assign out_err   = st_q.oerr;
endmodule

// File: rtl/cyc_syn_dec_chk.sv
module cyc_syn_dec_chk #(
    parameter int unsigned N = 7,
    parameter int unsigned R = 3,
    parameter logic [R:0]  GEN = 4'b1101,
    localparam int unsigned K = N - R,
    localparam int unsigned CW = $clog2(N)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_bit,
    input logic         out_valid,
    input logic [N-1:0] out_word,
    input logic [K-1:0] out_data,
    input logic         out_err
);
    logic [CW-1:0] beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                                beats_q <= '0;
        else if (in_valid && beats_q == CW'(N-1)) beats_q <= '0;
        else if (in_valid)                         beats_q <= beats_q + 1'b1;
    end

    function automatic logic [R-1:0] word_rem(input logic [N-1:0] w);
        logic [R:0]   t;
        logic [R-1:0] r;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            t = {r, w[i]};
            if (t[R]) t = t ^ GEN;
            r = t[R-1:0];
        end
        return r;
    endfunction

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && out_word == '0 && !out_err));
    // R2
    data_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_data == out_word[N-1:R]);
    // R6
    strobe_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && beats_q == CW'(N-1)) |=> out_valid);
    // R6
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && beats_q == CW'(N-1)));
    // R6
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R10
    codeword_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (word_rem(out_word) == '0));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_word) && !out_valid));

    logic unused_ok;
    assign unused_ok = in_bit ^ out_err;
endmodule

bind cyc_syn_dec cyc_syn_dec_chk #(.N(N), .R(R), .GEN(GEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_word(out_word), .out_data(out_data),
    .out_err(out_err)
);

// File: tb/tb_cyc_syn_dec.sv
`timescale 1ns/1ps
module tb_cyc_syn_dec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       out_valid;
    logic [6:0] out_word;
    logic [3:0] out_data;
    logic       out_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic       pend = 0;
    logic [6:0] exp_word;
    logic       exp_err;
    string      exp_tag;

    always #4 clk = ~clk;

    cyc_syn_dec dut (.*);

    function automatic logic [2:0] rem7(input logic [6:0] w);
        logic [3:0] t;
        logic [2:0] r;
        r = 3'b000;
        for (int i = 6; i >= 0; i--) begin
            t = {r, w[i]};
            if (t[3]) t = t ^ 4'b1101;
            r = t[2:0];
        end
        return r;
    endfunction

    function automatic logic [6:0] encode(input logic [3:0] d);
        return {d, rem7({d, 3'b000})};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_check();
        chk(out_valid == 1'b1, {exp_tag, " R6 out_valid"}, 16'(out_valid), 16'd1);
        chk(out_word == exp_word, {exp_tag, " word"}, 16'(out_word), 16'(exp_word));
        chk(out_data == exp_word[6:3], {exp_tag, " R2 data"}, 16'(out_data), 16'(exp_word[6:3]));
        chk(out_err == exp_err, {exp_tag, " R3 err flag"}, 16'(out_err), 16'(exp_err));
        pend = 0;
    endtask

    task automatic send(input logic [6:0] w, input logic [6:0] ew, input logic ee, input string tag);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i == 0 && pend) do_check();
            if (i == 1) chk(out_valid == 1'b0, "R6 strobe width", 16'(out_valid), 16'd0);
            in_valid = 1'b1;
            in_bit   = w[6-i];
        end
        pend = 1; exp_word = ew; exp_err = ee; exp_tag = tag;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pend) do_check();
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 strobe drops", 16'(out_valid), 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_valid == 0 && out_word == 0 && out_err == 0, "R1 in reset",
            16'({out_valid, out_err, out_word}), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && out_word == 0 && out_err == 0, "R1 after reset",
            16'({out_valid, out_err, out_word}), 16'd0);

        // R8 stated examples
        send(7'b1010011, 7'b1010001, 1'b1, "R8 example A");
        send(7'b1011010, 7'b0011010, 1'b1, "R8 example B");
        flush();

        // R9 double errors miscorrect
        send(7'b0000011, 7'b0100011, 1'b1, "R9 double 0000011");
        send(7'b1000001, 7'b1010001, 1'b1, "R9 double 1000001");
        flush();

        // R5 position map: single error on zero word flips the predicted bit
        for (int p = 0; p < 7; p++) begin
            logic [6:0] e;
            e = 7'b1000000 >> p;
            send(e, 7'b0000000, 1'b1, "R5 map on zero word");
        end
        flush();

        // R3 clean words, R4 every single error, R7 back to back
        for (int d = 0; d < 16; d++) begin
            logic [6:0] cw;
            cw = encode(4'(d));
            send(cw, cw, 1'b0, "R3 clean codeword");
            for (int p = 0; p < 7; p++)
                send(cw ^ (7'b1000000 >> p), cw, 1'b1, "R4 single error");
        end
        flush();

        // R7 idle cycles pause the count
        begin
            logic [6:0] cw;
            cw = encode(4'b1011) ^ 7'b0000100;
            for (int i = 0; i < 7; i++) begin
                @(negedge clk);
                in_valid = 1'b1; in_bit = cw[6-i];
                @(negedge clk);
                in_valid = 1'b0; in_bit = ~in_bit;
                if (i < 6) chk(out_valid == 1'b0, "R7 gap no early strobe", 16'(out_valid), 16'd0);
            end
            pend = 1; exp_word = encode(4'b1011); exp_err = 1'b1; exp_tag = "R7 gapped word";
            // result registered on the edge after bit 7; current negedge follows it
            do_check();
            @(negedge clk);
            chk(out_valid == 1'b0, "R6 strobe drops after gap", 16'(out_valid), 16'd0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule